// File: doc/BRIEF.md
# Two-Buffer Frame Transmit Engine

The block is a memory-mapped transmit engine with two packet buffers of `BUF_BYTES` bytes each. Software fills a buffer with frame data over a 32-bit word-addressed register bus, writes the byte count into that buffer's length register, and then writes a command into the buffer's control register. Two command bits in the control register choose between sending the buffered bytes out as a byte stream with valid/ready/last handshaking, and loading a 48-bit station address from the first six bytes of the buffer.

Packet data is held most-significant byte first: the first byte sent from any word is bits 31:24. The command bits stay set while a command waits or runs, so software can poll them to learn when the buffer is free. A finished command can raise a one-cycle interrupt pulse. Each buffer has its own enable bit for this pulse, and a single global enable gates both buffers. Preamble, frame check sequence and line signalling are handled elsewhere.

Top module: `pingpong_tx_engine`

## Requirements
- R1: After reset, the length, control and global enable registers all read 0. `tx_valid`, `irq` and `bus_rvalid` are low, and `mac_addr` equals `MAC_INIT`.
- R2: A read strobe returns data on `bus_rdata` with `bus_rvalid` high in the following cycle. The register words return their stored value. Buffer data words, and word 0x3FE (which has no register), read as 0.
- R3: Register word addresses are: length of buffer 0 at 0x1FD, global enable at 0x1FE, control of buffer 0 at 0x1FF, length of buffer 1 at 0x3FD and control of buffer 1 at 0x3FF. A write to a length register or to the global enable register stores the value unchanged. A control write with bit 0 clear stores the value with bits 1:0 cleared and starts nothing.
- R4: A control write with bit 0 = 1 and bit 1 = 0 sends the number of bytes held in the low bits of that buffer's length register. The bytes start at the buffer base, and within each word bits 31:24 go first, then 23:16, then 15:8, then 7:0. `tx_last` is high with the final byte only.
- R5: A transmit command with length 0 sends no bytes and completes.
- R6: A control write with bits 1:0 = 2'b11 loads `mac_addr` with the buffer's first six bytes, the first byte landing in bits 47:40. No bytes are sent.
- R7: Control bits 1:0 keep their written value while the command waits or runs, and both bits read 0 after it completes. The other control bits are kept.
- R8: A control write to a buffer whose bit 0 is still set is ignored.
- R9: `irq` goes high for exactly one cycle, in the cycle after a command completes, and only if bit 3 of that buffer's control register and bit 31 of the global enable register are both set. Completion of a transmit is the clock edge of its final byte handshake.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_word | input | ADDR_W | Word address; top bit selects the buffer |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Downstream accepts the byte |
| mac_addr | output | 48 | Station address register |
| irq | output | 1 | One-cycle completion pulse |

## Verification
Read data is due exactly one cycle after the strobe, and the bench samples it at the falling edge that follows the edge capturing the strobe. Any stream byte that is valid is compared with the head of a queue of expected bytes on every cycle it is shown, including stalled cycles. A byte is removed from the queue only when `tx_ready` is also high. The expected interrupt for a transmit is due at the falling edge just after the final byte's handshake edge, and every other cycle must show `irq` low. For address loads and zero-length frames the completion cycle is internal, so the bench allows exactly one pulse within a ten-cycle window and then checks the address register and the cleared command bits.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  localparam int DW        = 32;
  localparam int NBUF      = 2;
  localparam int CTL_START = 0;
  localparam int CTL_PROG  = 1;
  localparam int CTL_IEN   = 3;
  localparam int GIE_BIT   = 31;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CAPT,
    ST_EMIT,
    ST_MAC0,
    ST_MAC1,
    ST_MAC2
  } eng_state_t;
endpackage

// File: rtl/ptx_ram.sv
module ptx_ram #(
  parameter int DEPTH = 1024,
  parameter int AW    = 10,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ptx_regfile.sv
module ptx_regfile
  import ptx_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int ADDR_W    = 10,
  parameter int LEN_W     = 11
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_word,
  input  logic [DW-1:0]               bus_wdata,
  output logic [DW-1:0]               bus_rdata,
  output logic                        bus_rvalid,
  output logic                        ram_we,
  output logic [ADDR_W-1:0]           ram_waddr,
  output logic [DW-1:0]               ram_wdata,
  output logic [NBUF-1:0]             pend,
  output logic [NBUF-1:0]             prog,
  output logic [NBUF-1:0]             ien,
  output logic [NBUF-1:0][LEN_W-1:0]  len,
  output logic                        gie_on,
  input  logic                        done,
  input  logic                        done_buf
);
  localparam int WORDS = BUF_BYTES / 4;
  localparam int OFF_W = ADDR_W - 1;
  localparam logic [OFF_W-1:0] OFF_LEN = OFF_W'(WORDS - 3);
  localparam logic [OFF_W-1:0] OFF_GIE = OFF_W'(WORDS - 2);
  localparam logic [OFF_W-1:0] OFF_CTL = OFF_W'(WORDS - 1);

  logic             sel_buf;
  logic [OFF_W-1:0] off;
  logic             hit_len, hit_ctl, hit_gie, is_reg;
  logic [DW-1:0]    gie_q;
  logic [NBUF-1:0][DW-1:0] len_all;
  logic [NBUF-1:0][DW-1:0] ctl_all;

  assign sel_buf = bus_word[ADDR_W-1];
  assign off     = bus_word[OFF_W-1:0];
  assign hit_len = (off == OFF_LEN);
  assign hit_ctl = (off == OFF_CTL);
  assign hit_gie = (off == OFF_GIE) && !sel_buf;
  assign is_reg  = hit_len || hit_ctl || (off == OFF_GIE);

  assign ram_we    = bus_wr && !is_reg;
  assign ram_waddr = bus_word;
  assign ram_wdata = bus_wdata;
  assign gie_on    = gie_q[GIE_BIT];

  generate
    for (genvar b = 0; b < NBUF; b++) begin : g_buf
      logic          wsel;
      logic [DW-1:0] len_q;
      logic [DW-1:0] ctl_q;

      assign wsel = bus_wr && (sel_buf == 1'(b));

      always_ff @(posedge clk) begin
        if (rst) begin
          len_q <= '0;
          ctl_q <= '0;
        end else begin
          if (wsel && hit_len) len_q <= bus_wdata;
          if (done && (done_buf == 1'(b))) begin
            ctl_q[CTL_PROG]  <= 1'b0;
            ctl_q[CTL_START] <= 1'b0;
          end else if (wsel && hit_ctl && !ctl_q[CTL_START]) begin
            ctl_q <= bus_wdata[CTL_START] ? bus_wdata
                                          : {bus_wdata[DW-1:2], 2'b00};
          end
        end
      end

      assign len_all[b] = len_q;
      assign ctl_all[b] = ctl_q;
      assign pend[b]    = ctl_q[CTL_START];
      assign prog[b]    = ctl_q[CTL_PROG];
      assign ien[b]     = ctl_q[CTL_IEN];
      assign len[b]     = len_q[LEN_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q      <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      if (bus_wr && hit_gie) gie_q <= bus_wdata;
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        if (hit_len)      bus_rdata <= len_all[sel_buf];
        else if (hit_ctl) bus_rdata <= ctl_all[sel_buf];
        else if (hit_gie) bus_rdata <= gie_q;
        else              bus_rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/ptx_engine.sv
module ptx_engine
  import ptx_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 11
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NBUF-1:0]            pend,
  input  logic [NBUF-1:0]            prog,
  input  logic [NBUF-1:0][LEN_W-1:0] len,
  output logic [ADDR_W-1:0]          raddr,
  input  logic [DW-1:0]              rdata,
  output logic                       tx_valid,
  output logic [7:0]                 tx_data,
  output logic                       tx_last,
  input  logic                       tx_ready,
  output logic                       done,
  output logic                       done_buf,
  output logic                       mac_load,
  output logic [47:0]                mac_val
);
  localparam int OFF_W = ADDR_W - 1;

  eng_state_t       st;
  logic             cur;
  logic [OFF_W-1:0] wptr;
  logic [LEN_W-1:0] remain;
  logic [DW-1:0]    hold;
  logic [1:0]       bsel;
  logic [DW-1:0]    mac_hi;
  logic             pick, any, hs, zero_start;

  assign any        = |pend;
  assign pick       = pend[0] ? 1'b0 : 1'b1;
  assign hs         = tx_valid && tx_ready;
  assign zero_start = (st == ST_IDLE) && any && !prog[pick] && (len[pick] == '0);
  assign raddr      = {cur, wptr};
  assign done       = zero_start || (st == ST_EMIT && hs && tx_last) || (st == ST_MAC2);
  assign done_buf   = (st == ST_IDLE) ? pick : cur;
  assign mac_load   = (st == ST_MAC2);
  assign mac_val    = {mac_hi, rdata[31:16]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cur      <= 1'b0;
      wptr     <= '0;
      remain   <= '0;
      hold     <= '0;
      bsel     <= '0;
      mac_hi   <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
      tx_last  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (any) begin
            cur    <= pick;
            wptr   <= '0;
            remain <= len[pick];
            if (prog[pick])             st <= ST_MAC0;
            else if (len[pick] != '0)   st <= ST_FETCH;
          end
        end
        ST_FETCH: st <= ST_CAPT;
        ST_CAPT: begin
          tx_valid <= 1'b1;
          tx_data  <= rdata[31:24];
          hold     <= {rdata[23:0], 8'h00};
          tx_last  <= (remain == LEN_W'(1));
          bsel     <= '0;
          wptr     <= wptr + 1'b1;
          st       <= ST_EMIT;
        end
        ST_EMIT: begin
          if (hs) begin
            remain <= remain - 1'b1;
            if (tx_last) begin
              tx_valid <= 1'b0;
              tx_last  <= 1'b0;
              st       <= ST_IDLE;
            end else if (bsel == 2'd3) begin
              tx_valid <= 1'b0;
              st       <= ST_FETCH;
            end else begin
              bsel    <= bsel + 1'b1;
              tx_data <= hold[31:24];
              hold    <= {hold[23:0], 8'h00};
              tx_last <= (remain == LEN_W'(2));
            end
          end
        end
        ST_MAC0: begin
          wptr <= OFF_W'(1);
          st   <= ST_MAC1;
        end
        ST_MAC1: begin
          mac_hi <= rdata;
          st     <= ST_MAC2;
        end
        ST_MAC2: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pingpong_tx_engine.sv
module pingpong_tx_engine
  import ptx_pkg::*;
#(
  parameter int          BUF_BYTES = 2048,
  parameter logic [47:0] MAC_INIT  = 48'h0,
  parameter int          ADDR_W    = $clog2(BUF_BYTES / 4) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_word,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready,
  output logic [47:0]       mac_addr,
  output logic              irq
);
  localparam int DEPTH = NBUF * (BUF_BYTES / 4);
  localparam int LEN_W = $clog2(BUF_BYTES);

  logic                       ram_we;
  logic [ADDR_W-1:0]          ram_waddr, ram_raddr;
  logic [DW-1:0]              ram_wdata, ram_rdata;
  logic [NBUF-1:0]            pend, prog, ien;
  logic [NBUF-1:0][LEN_W-1:0] len;
  logic                       gie_on;
  logic                       eng_done, eng_done_buf, mac_load;
  logic [47:0]                mac_val;

  ptx_regfile #(.BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_word(bus_word), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .pend(pend), .prog(prog), .ien(ien), .len(len), .gie_on(gie_on),
    .done(eng_done), .done_buf(eng_done_buf)
  );

  ptx_ram #(.DEPTH(DEPTH), .AW(ADDR_W), .WIDTH(DW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  ptx_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst(rst),
    .pend(pend), .prog(prog), .len(len),
    .raddr(ram_raddr), .rdata(ram_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .done(eng_done), .done_buf(eng_done_buf),
    .mac_load(mac_load), .mac_val(mac_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq      <= 1'b0;
      mac_addr <= MAC_INIT;
    end else begin
      irq <= eng_done && ien[eng_done_buf] && gie_on;
      if (mac_load) mac_addr <= mac_val;
    end
  end
endmodule

// File: rtl/ptx_checker.sv
module ptx_checker (
  input logic        clk,
  input logic        rst,
  input logic        irq,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        tx_last,
  input logic        bus_rd,
  input logic        bus_rvalid,
  input logic        gie_on,
  input logic        done,
  input logic        mac_load,
  input logic [47:0] mac_addr
);
  p_irq_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_irq_needs_gie_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(gie_on));

  p_irq_after_done_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(done));

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  p_last_with_valid_r4: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid);

  p_read_latency_r2: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  p_mac_only_on_load_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(mac_addr) |-> $past(mac_load));
endmodule

bind pingpong_tx_engine ptx_checker u_chk (
  .clk(clk), .rst(rst), .irq(irq),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
  .bus_rd(bus_rd), .bus_rvalid(bus_rvalid),
  .gie_on(gie_on), .done(eng_done), .mac_load(mac_load), .mac_addr(mac_addr)
);

// File: tb/sim_pingpong_tx_engine.sv
module sim_pingpong_tx_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam logic [AW-1:0] W_LEN0 = 10'h1FD, W_GIE = 10'h1FE, W_CTL0 = 10'h1FF;
  localparam logic [AW-1:0] W_BUF1 = 10'h200, W_LEN1 = 10'h3FD, W_HOLE = 10'h3FE;
  localparam logic [AW-1:0] W_CTL1 = 10'h3FF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_word = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic          tx_valid, tx_last;
  logic [7:0]    tx_data;
  logic          tx_ready = 1'b0;
  logic [47:0]   mac_addr;
  logic          irq;

  pingpong_tx_engine u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .mac_addr(mac_addr), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [8:0] exp_q[$];
  bit tx_irq_flag = 0;
  bit irq_due_v = 0, irq_due = 0;
  bit loose_on = 0, loose_flag = 0, loose_seen = 0;
  int stall_mode = 1;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_word = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_word = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
    @(negedge clk);
    check(req, "read valid", 64'(bus_rvalid), 64'(1));
    check(req, "read data", 64'(bus_rdata), 64'(exp));
  endtask

  task automatic push_frame(input int n, input logic [31:0] w0, input logic [31:0] w1,
                            input logic [31:0] w2);
    for (int i = 0; i < n; i++) begin
      logic [31:0] w;
      logic [7:0]  b;
      w = (i < 4) ? w0 : (i < 8) ? w1 : w2;
      b = 8'(w >> (8 * (3 - (i % 4))));
      exp_q.push_back({(i == n - 1), b});
    end
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  // ready pattern driver
  initial forever begin
    @(posedge clk); #1;
    if (stall_mode == 0)      tx_ready = 1'b1;
    else if (stall_mode == 1) tx_ready = 1'b0;
    else begin
      tx_ready = lfsr[0] | lfsr[3];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
  end

  // reference model, compared every cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (irq_due_v) begin
        check("R9", "irq after final byte", 64'(irq), 64'(irq_due));
        irq_due_v = 0;
      end else if (irq) begin
        if (loose_on) begin
          check("R9", "irq for command", 64'(1), 64'(loose_flag));
          loose_on = 0;
          loose_seen = 1;
        end else check("R9", "spurious irq", 64'(irq), 64'(0));
      end else n_chk++;
      if (tx_valid) begin
        if (exp_q.size() == 0) check("R4", "unexpected byte", 64'(1), 64'(0));
        else begin
          check("R4", "byte and last (R10 while stalled)", 64'({tx_last, tx_data}), 64'(exp_q[0]));
          if (tx_ready) begin
            if (exp_q[0][8]) begin
              irq_due = tx_irq_flag;
              irq_due_v = 1;
            end
            void'(exp_q.pop_front());
          end
        end
      end
    end
  end

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "tx_valid", 64'(tx_valid), 64'(0));
    check("R1", "irq", 64'(irq), 64'(0));
    check("R1", "rvalid", 64'(bus_rvalid), 64'(0));
    check("R1", "mac", 64'(mac_addr), 64'(0));
    rd_chk(W_LEN0, 32'h0, "R1");
    rd_chk(W_LEN1, 32'h0, "R1");
    rd_chk(W_GIE, 32'h0, "R1");
    rd_chk(W_CTL0, 32'h0, "R1");
    rd_chk(W_CTL1, 32'h0, "R1");

    // R3 plain register writes, control with start clear
    wr(W_LEN1, 32'hDEAD_BEEF);
    rd_chk(W_LEN1, 32'hDEAD_BEEF, "R3");
    wr(W_GIE, 32'h8000_0001);
    rd_chk(W_GIE, 32'h8000_0001, "R3");
    wr(W_CTL0, 32'hFFFF_FFFE);
    rd_chk(W_CTL0, 32'hFFFF_FFFC, "R3");

    // R2 data and hole read as zero
    wr(10'h004, 32'h1234_5678);
    rd_chk(10'h004, 32'h0, "R2");
    wr(W_HOLE, 32'h5555_AAAA);
    rd_chk(W_HOLE, 32'h0, "R2");

    // R4 R7 R8 R10 stalled transmit from buffer 0
    stall_mode = 1;
    wr(10'h000, 32'h1122_3344);
    wr(10'h001, 32'h5566_7788);
    wr(W_LEN0, 32'h0000_0007);
    wr(W_GIE, 32'h8000_0000);
    tx_irq_flag = 1;
    push_frame(7, 32'h1122_3344, 32'h5566_7788, 32'h0);
    wr(W_CTL0, 32'h0000_0009);
    repeat (4) @(posedge clk);
    rd_chk(W_CTL0, 32'h0000_0009, "R7");
    wr(W_CTL0, 32'h0000_0000);
    rd_chk(W_CTL0, 32'h0000_0009, "R8");
    stall_mode = 2;
    drain();
    check("R4", "frame fully sent", 64'(exp_q.size()), 64'(0));
    rd_chk(W_CTL0, 32'h0000_0008, "R7");

    // R6 address load from buffer 1
    stall_mode = 0;
    wr(W_BUF1, 32'h02AA_BBCC);
    wr(W_BUF1 + 10'h1, 32'hDDEE_FF99);
    loose_on = 1; loose_flag = 1; loose_seen = 0;
    wr(W_CTL1, 32'h0000_000B);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R6", "mac value", 64'(mac_addr), 64'(48'h02AA_BBCC_DDEE));
    check("R9", "irq seen for address load", 64'(loose_seen), 64'(1));
    loose_on = 0;
    rd_chk(W_CTL1, 32'h0000_0008, "R7");

    // R5 zero length frame
    wr(W_LEN1, 32'h0);
    loose_on = 1; loose_flag = 1; loose_seen = 0;
    wr(W_CTL1, 32'h0000_0009);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R5", "irq seen for empty frame", 64'(loose_seen), 64'(1));
    loose_on = 0;
    rd_chk(W_CTL1, 32'h0000_0008, "R5");

    // R9 gating: global enable off, nine bytes from buffer 1
    wr(W_GIE, 32'h0);
    wr(W_BUF1, 32'hA1A2_A3A4);
    wr(W_BUF1 + 10'h1, 32'hB1B2_B3B4);
    wr(W_BUF1 + 10'h2, 32'hC1C2_C3C4);
    wr(W_LEN1, 32'h0000_0009);
    tx_irq_flag = 0;
    push_frame(9, 32'hA1A2_A3A4, 32'hB1B2_B3B4, 32'hC1C2_C3C4);
    wr(W_CTL1, 32'h0000_0009);
    drain();
    check("R9", "gated frame sent", 64'(exp_q.size()), 64'(0));

    // R9 gating: buffer enable off, global on, one byte
    wr(W_GIE, 32'h8000_0000);
    wr(W_LEN0, 32'h0000_0001);
    tx_irq_flag = 0;
    push_frame(1, 32'h1122_3344, 32'h0, 32'h0);
    wr(W_CTL0, 32'h0000_0001);
    drain();
    rd_chk(W_CTL0, 32'h0000_0000, "R7");

    summary();
    $finish;
  end
endmodule